// File: doc/BRIEF.md
# Host-Firmware Mailbox Register Block

This block is the hardware meeting point between a host function and an embedded firmware agent. It holds a small shared address space with two regions. The data region holds one counter word that only firmware writes, one counter word that only the host writes, and a 16-word message buffer. The control region holds a host control register, a firmware control register and an interrupt mask. Each side reaches the block through its own read/write port, and every register and buffer word can be read from both ports.

Access to the message buffer is arbitrated by a lock. A side asks for the lock by writing the ownership bit of its own control register. It then reads the register back, and it holds the lock only if the bit reads back as one. A single host control write both drops ownership and, when bit 0 is set, posts a request to firmware. A posted request, or the host's final write to buffer word 0 after it has read a message, raises an interrupt towards firmware. Firmware reads clear each cause.

The counter words each pack a 16-bit request count in bits 15:0 and a 16-bit acknowledge count in bits 31:16. The block stores them but never interprets them. The host initialises the block by clearing its control register and setting mask bits 31:16.

Top module: `hfw_mailbox`

## Requirements
- R1: After a synchronous reset, the host control, firmware control, mask and both counter words read as zero, no request or read-done is pending, and `fw_irq` is low.
- R2: Address bit 7 selects the region: 1 for data, 0 for control. The data region has the firmware counter word at offset 0x00, the host counter word at 0x04, and buffer word k at 0x08+4k. The control region has the host control register at 0x00, the mask at 0x04 and the firmware control register at 0x08. Either port can read every location. Read data and `*_rvalid` appear in the cycle after the cycle of the read request.
- R3: The firmware counter word changes only on writes from the firmware port, and the host counter word changes only on writes from the host port. A write from the other port is ignored.
- R4: A host control write with bit 3 set grants the host lock only when firmware does not hold the lock. Host control bit 3 reads back the host lock state.
- R5: Any host control write with bit 3 clear releases the host lock. The same write with bit 0 set posts a request. The pending request reads back at bit 0 of both control registers.
- R6: Firmware takes the lock by writing bit 3 of its control register and gets it only when the host does not hold it. Firmware releases the lock by writing that bit as zero. The two locks are never held together. When both sides ask in the same cycle, firmware wins.
- R7: A pending request drives `fw_irq` high unless mask bit 16 is set. A firmware read of the host counter word clears the pending request.
- R8: A host write to buffer word 0 sets the read-done flag at bit 1 of the firmware control register. The flag drives `fw_irq` unless mask bit 17 is set. A firmware read of its control register clears the flag.
- R9: The buffer is 16 words deep. Reads beyond it, reads of unused control offsets and accesses with address bits 1:0 nonzero all return zero, and writes to those locations are ignored.
- R10: The mask register is written from the host port, stores all 32 bits, and reads back the same from both ports.
- R11: When both ports write the same buffer word in the same cycle, the firmware value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 8 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data |
| hst_rvalid | output | 1 | Host read data valid |
| fw_wr | input | 1 | Firmware write strobe |
| fw_rd | input | 1 | Firmware read strobe |
| fw_addr | input | 8 | Firmware byte address |
| fw_wdata | input | 32 | Firmware write data |
| fw_rdata | output | 32 | Firmware read data |
| fw_rvalid | output | 1 | Firmware read data valid |
| fw_irq | output | 1 | Interrupt towards firmware |

## Verification
The hardest case to reach is the lock tie, where both ports write their ownership bit in the very same cycle while neither side holds the lock. The stimulus reaches it with a dedicated task that drives both write strobes in one cycle, then reads back both control registers to show that firmware won. The same two-port task makes both sides write one buffer word in one cycle, which exercises the write collision. The interrupt path is checked with each cause posted under a mask and then unmasked. This shows that each cause is held and released correctly.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  // control register bit positions
  localparam int unsigned OWN_BIT  = 3;
  localparam int unsigned REQ_BIT  = 0;
  localparam int unsigned DONE_BIT = 1;
  // mask bit positions
  localparam int unsigned MSK_REQ_BIT  = 16;
  localparam int unsigned MSK_DONE_BIT = 17;
  // word indices inside the control region
  localparam int unsigned CW_HCTRL = 0;
  localparam int unsigned CW_MASK  = 1;
  localparam int unsigned CW_FCTRL = 2;
  // word indices inside the data region
  localparam int unsigned DW_FCNT  = 0;
  localparam int unsigned DW_HCNT  = 1;
  localparam int unsigned DW_BUF0  = 2;

  typedef struct packed {
    logic hctrl;
    logic mask;
    logic fctrl;
    logic fcnt;
    logic hcnt;
    logic bufw;
  } sel_t;

  typedef struct packed {
    logic set;
    logic clr;
  } lock_req_t;
endpackage

// File: rtl/mbx_port_dec.sv
`timescale 1ns/1ps
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 16,
  localparam int WI_W     = ADDR_W - 3,
  localparam int BUF_AW   = $clog2(BUF_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [BUF_AW-1:0] buf_idx
);
  localparam logic [WI_W:0] BUF_END = (WI_W+1)'(DW_BUF0 + BUF_WORDS);

  logic            aligned;
  logic            in_data;
  logic [WI_W-1:0] wi;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    in_data   = addr[ADDR_W-1];
    wi        = addr[ADDR_W-2:2];
    sel.hctrl = aligned && !in_data && (wi == WI_W'(CW_HCTRL));
    sel.mask  = aligned && !in_data && (wi == WI_W'(CW_MASK));
    sel.fctrl = aligned && !in_data && (wi == WI_W'(CW_FCTRL));
    sel.fcnt  = aligned &&  in_data && (wi == WI_W'(DW_FCNT));
    sel.hcnt  = aligned &&  in_data && (wi == WI_W'(DW_HCNT));
    sel.bufw  = aligned &&  in_data && (wi >= WI_W'(DW_BUF0)) && ({1'b0, wi} < BUF_END);
    buf_idx   = BUF_AW'(wi - WI_W'(DW_BUF0));
  end
endmodule

// File: rtl/mbx_lock_arb.sv
`timescale 1ns/1ps
module mbx_lock_arb
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lock_req_t h_req,
  input  lock_req_t f_req,
  output logic      host_own,
  output logic      fw_own
);
  // firmware is granted against the current host state; the host is
  // refused whenever firmware holds or asks in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      host_own <= 1'b0;
      fw_own   <= 1'b0;
    end else begin
      if (f_req.clr)
        fw_own <= 1'b0;
      else if (f_req.set && !host_own)
        fw_own <= 1'b1;

      if (h_req.clr)
        host_own <= 1'b0;
      else if (h_req.set && !fw_own && !f_req.set)
        host_own <= 1'b1;
    end
  end
endmodule

// File: rtl/mbx_buffer.sv
`timescale 1ns/1ps
module mbx_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [AW-1:0]     a_idx,
  input  logic [DATA_W-1:0] a_wd,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [AW-1:0]     b_idx,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // port b is written after port a so it wins a same-word collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_idx] <= a_wd;
    if (b_we) mem[b_idx] <= b_wd;
  end

  always_ff @(posedge clk) begin
    if (a_re) a_q <= mem[a_idx];
    if (b_re) b_q <= mem[b_idx];
  end
endmodule

// File: rtl/mbx_event.sv
`timescale 1ns/1ps
module mbx_event
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post,
  input  logic              req_ack,
  input  logic              done_set,
  input  logic              done_ack,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wd,
  output logic [DATA_W-1:0] mask_q,
  output logic              req_pend,
  output logic              rd_done,
  output logic              irq
);
  logic              req_n;
  logic              done_n;
  logic [DATA_W-1:0] mask_n;

  always_comb begin
    req_n  = post     | (req_pend & ~req_ack);
    done_n = done_set | (rd_done  & ~done_ack);
    mask_n = mask_we ? mask_wd : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_pend <= 1'b0;
      rd_done  <= 1'b0;
      mask_q   <= '0;
      irq      <= 1'b0;
    end else begin
      req_pend <= req_n;
      rd_done  <= done_n;
      mask_q   <= mask_n;
      irq      <= (req_n & ~mask_n[MSK_REQ_BIT]) | (done_n & ~mask_n[MSK_DONE_BIT]);
    end
  end
endmodule

// File: rtl/hfw_mailbox.sv
`timescale 1ns/1ps
module hfw_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_rvalid,
  input  logic              fw_wr,
  input  logic              fw_rd,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [DATA_W-1:0] fw_wdata,
  output logic [DATA_W-1:0] fw_rdata,
  output logic              fw_rvalid,
  output logic              fw_irq
);
  localparam int BUF_AW = $clog2(BUF_WORDS);
  localparam int NPORT  = 2;   // 0 = host, 1 = firmware

  logic [NPORT-1:0]  p_wr, p_rd, p_rvalid;
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic [DATA_W-1:0] p_wd    [NPORT];
  logic [DATA_W-1:0] p_rdata [NPORT];
  logic [DATA_W-1:0] p_bq    [NPORT];
  logic [BUF_AW-1:0] p_bidx  [NPORT];
  sel_t              p_sel   [NPORT];

  logic              host_lock, fw_lock;
  logic              req_pend, rd_done;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] fcnt_q, hcnt_q;
  lock_req_t         h_lreq, f_lreq;

  assign p_wr      = {fw_wr, hst_wr};
  assign p_rd      = {fw_rd, hst_rd};
  assign p_addr[0] = hst_addr;
  assign p_addr[1] = fw_addr;
  assign p_wd[0]   = hst_wdata;
  assign p_wd[1]   = fw_wdata;

  generate
    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
      logic [DATA_W-1:0] reg_view;
      logic [DATA_W-1:0] reg_q;
      logic              bufsel_q;
      logic              vld_q;

      mbx_port_dec #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_dec (
        .addr    (p_addr[gp]),
        .sel     (p_sel[gp]),
        .buf_idx (p_bidx[gp])
      );

      always_comb begin
        reg_view = '0;
        if (p_sel[gp].hctrl) begin
          reg_view[OWN_BIT] = host_lock;
          reg_view[REQ_BIT] = req_pend;
        end
        if (p_sel[gp].fctrl) begin
          reg_view[OWN_BIT]  = fw_lock;
          reg_view[DONE_BIT] = rd_done;
          reg_view[REQ_BIT]  = req_pend;
        end
        if (p_sel[gp].mask) reg_view = mask_q;
        if (p_sel[gp].fcnt) reg_view = fcnt_q;
        if (p_sel[gp].hcnt) reg_view = hcnt_q;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q    <= 1'b0;
          reg_q    <= '0;
          bufsel_q <= 1'b0;
        end else begin
          vld_q <= p_rd[gp];
          if (p_rd[gp]) begin
            reg_q    <= reg_view;
            bufsel_q <= p_sel[gp].bufw;
          end
        end
      end

      assign p_rdata[gp]  = bufsel_q ? p_bq[gp] : reg_q;
      assign p_rvalid[gp] = vld_q;
    end
  endgenerate

  assign hst_rdata  = p_rdata[0];
  assign fw_rdata   = p_rdata[1];
  assign hst_rvalid = p_rvalid[0];
  assign fw_rvalid  = p_rvalid[1];

  // counter words: each one has a single writing side
  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      if (fw_wr  && p_sel[1].fcnt) fcnt_q <= fw_wdata;
      if (hst_wr && p_sel[0].hcnt) hcnt_q <= hst_wdata;
    end
  end

  always_comb begin
    h_lreq.set = hst_wr && p_sel[0].hctrl &&  hst_wdata[OWN_BIT];
    h_lreq.clr = hst_wr && p_sel[0].hctrl && !hst_wdata[OWN_BIT];
    f_lreq.set = fw_wr  && p_sel[1].fctrl &&  fw_wdata[OWN_BIT];
    f_lreq.clr = fw_wr  && p_sel[1].fctrl && !fw_wdata[OWN_BIT];
  end

  mbx_lock_arb u_lock (
    .clk      (clk),
    .rst      (rst),
    .h_req    (h_lreq),
    .f_req    (f_lreq),
    .host_own (host_lock),
    .fw_own   (fw_lock)
  );

  mbx_buffer #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS)) u_buf (
    .clk   (clk),
    .a_we  (hst_wr && p_sel[0].bufw),
    .a_re  (hst_rd && p_sel[0].bufw),
    .a_idx (p_bidx[0]),
    .a_wd  (hst_wdata),
    .a_q   (p_bq[0]),
    .b_we  (fw_wr && p_sel[1].bufw),
    .b_re  (fw_rd && p_sel[1].bufw),
    .b_idx (p_bidx[1]),
    .b_wd  (fw_wdata),
    .b_q   (p_bq[1])
  );

  mbx_event #(.DATA_W(DATA_W)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .post     (hst_wr && p_sel[0].hctrl && hst_wdata[REQ_BIT]),
    .req_ack  (fw_rd && p_sel[1].hcnt),
    .done_set (hst_wr && p_sel[0].bufw && (p_bidx[0] == '0)),
    .done_ack (fw_rd && p_sel[1].fctrl),
    .mask_we  (hst_wr && p_sel[0].mask),
    .mask_wd  (hst_wdata),
    .mask_q   (mask_q),
    .req_pend (req_pend),
    .rd_done  (rd_done),
    .irq      (fw_irq)
  );
endmodule

// File: rtl/mbx_chk.sv
`timescale 1ns/1ps
module mbx_chk #(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 16,
  parameter int DATA_W    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hst_wr,
  input logic              hst_rd,
  input logic [ADDR_W-1:0] hst_addr,
  input logic              hst_own_bit,
  input logic [DATA_W-1:0] hst_rdata,
  input logic              hst_rvalid,
  input logic              fw_wr,
  input logic [ADDR_W-1:0] fw_addr,
  input logic              fw_own_bit,
  input logic              fw_irq,
  input logic              host_lock,
  input logic              fw_lock
);
  localparam int WI_W = ADDR_W - 3;

  logic h_own, f_own, h_zero;
  assign h_own  = hst_wr && (hst_addr == ADDR_W'(0)) && hst_own_bit;
  assign f_own  = fw_wr  && (fw_addr  == ADDR_W'(8)) && fw_own_bit;
  assign h_zero = hst_addr[ADDR_W-1] &&
                  ((hst_addr[1:0] != 2'b00) || (hst_addr[ADDR_W-2:2] >= WI_W'(2 + BUF_WORDS)));

  p_lock_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(host_lock && fw_lock));

  p_fw_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (h_own && f_own && !host_lock && !fw_lock) |=> (fw_lock && !host_lock));

  p_lock_src_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(host_lock) |-> $past(h_own));

  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    hst_rd |=> hst_rvalid);

  p_no_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    !hst_rd |=> !hst_rvalid);

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && h_zero) |=> (hst_rdata == '0));

  p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fw_irq) |-> $past(hst_wr));
endmodule

bind hfw_mailbox mbx_chk #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hst_wr      (hst_wr),
  .hst_rd      (hst_rd),
  .hst_addr    (hst_addr),
  .hst_own_bit (hst_wdata[3]),
  .hst_rdata   (hst_rdata),
  .hst_rvalid  (hst_rvalid),
  .fw_wr       (fw_wr),
  .fw_addr     (fw_addr),
  .fw_own_bit  (fw_wdata[3]),
  .fw_irq      (fw_irq),
  .host_lock   (host_lock),
  .fw_lock     (fw_lock)
);

// File: tb/sim_hfw_mailbox.sv
`timescale 1ns/1ps
module sim_hfw_mailbox;
  localparam logic [7:0] A_HCTRL = 8'h00;
  localparam logic [7:0] A_MASK  = 8'h04;
  localparam logic [7:0] A_FCTRL = 8'h08;
  localparam logic [7:0] A_FCNT  = 8'h80;
  localparam logic [7:0] A_HCNT  = 8'h84;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 0, hst_rd = 0, fw_wr = 0, fw_rd = 0;
  logic [7:0]  hst_addr = 0, fw_addr = 0;
  logic [31:0] hst_wdata = 0, fw_wdata = 0;
  logic [31:0] hst_rdata, fw_rdata;
  logic        hst_rvalid, fw_rvalid, fw_irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] hq_d[$];
  string       hq_t[$];
  logic [31:0] fq_d[$];
  string       fq_t[$];

  always #2.5 clk = ~clk;

  hfw_mailbox u0 (
    .clk(clk), .rst(rst),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .fw_wr(fw_wr), .fw_rd(fw_rd), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
    .fw_rdata(fw_rdata), .fw_rvalid(fw_rvalid), .fw_irq(fw_irq)
  );

  function automatic logic [7:0] bufa(input int k);
    return 8'(8'h88 + 4 * k);
  endfunction

  // monitor: pop expected read data as each port returns it
  always @(negedge clk) begin
    logic [31:0] d;
    string       t;
    if (!rst && hst_rvalid) begin
      checks++;
      if (hq_d.size() == 0) begin
        errors++;
        $display("FAIL host unexpected read data actual %h expected none", hst_rdata);
      end else begin
        d = hq_d.pop_front();
        t = hq_t.pop_front();
        if (hst_rdata !== d) begin
          errors++;
          $display("FAIL %s host read actual %h expected %h", t, hst_rdata, d);
        end
      end
    end
    if (!rst && fw_rvalid) begin
      checks++;
      if (fq_d.size() == 0) begin
        errors++;
        $display("FAIL fw unexpected read data actual %h expected none", fw_rdata);
      end else begin
        d = fq_d.pop_front();
        t = fq_t.pop_front();
        if (fw_rdata !== d) begin
          errors++;
          $display("FAIL %s fw read actual %h expected %h", t, fw_rdata, d);
        end
      end
    end
  end

  // all tasks start and end one time unit after a rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    step();
    hst_wr = 0;
  endtask

  task automatic fw(input logic [7:0] a, input logic [31:0] d);
    fw_wr = 1; fw_addr = a; fw_wdata = d;
    step();
    fw_wr = 0;
  endtask

  task automatic both_wr(input logic [7:0] ha, input logic [31:0] hd,
                         input logic [7:0] fa, input logic [31:0] fd);
    hst_wr = 1; hst_addr = ha; hst_wdata = hd;
    fw_wr  = 1; fw_addr  = fa; fw_wdata  = fd;
    step();
    hst_wr = 0; fw_wr = 0;
  endtask

  task automatic hr(input logic [7:0] a, input logic [31:0] e, input string t);
    hq_d.push_back(e); hq_t.push_back(t);
    hst_rd = 1; hst_addr = a;
    step();
    hst_rd = 0;
  endtask

  task automatic fr(input logic [7:0] a, input logic [31:0] e, input string t);
    fq_d.push_back(e); fq_t.push_back(t);
    fw_rd = 1; fw_addr = a;
    step();
    fw_rd = 0;
  endtask

  task automatic ck_irq(input logic e, input string t);
    checks++;
    if (fw_irq !== e) begin
      errors++;
      $display("FAIL %s fw_irq actual %b expected %b", t, fw_irq, e);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    step();

    // R1 reset state
    ck_irq(1'b0, "R1");
    hr(A_HCTRL, 32'h0, "R1");
    hr(A_MASK,  32'h0, "R1");
    fr(A_FCTRL, 32'h0, "R1");
    hr(A_FCNT,  32'h0, "R1");
    hr(A_HCNT,  32'h0, "R1");

    // host init and mask storage, R10
    hw(A_HCTRL, 32'h0);
    hw(A_MASK, 32'hFFFF_0000);
    fr(A_MASK, 32'hFFFF_0000, "R10");
    hr(A_MASK, 32'hFFFF_0000, "R10");

    // counter word ownership, R3
    fw(A_FCNT, 32'h0001_0001);
    fw(A_HCNT, 32'hDEAD_BEEF);
    hr(A_FCNT, 32'h0001_0001, "R3");
    hw(A_FCNT, 32'h1234_5678);
    hr(A_FCNT, 32'h0001_0001, "R3");
    fr(A_HCNT, 32'h0, "R3");

    // host lock, R4; firmware refused while host holds, R6
    hw(A_HCTRL, 32'h8);
    hr(A_HCTRL, 32'h8, "R4");
    fw(A_FCTRL, 32'h8);
    fr(A_FCTRL, 32'h0, "R6");

    // fill buffer, post request with release, R5/R7
    for (int k = 0; k < 16; k++) hw(bufa(k), 32'hA500_0000 | 32'(k));
    hw(A_HCNT, 32'h0000_0001);
    hw(A_HCTRL, 32'h1);
    step();
    ck_irq(1'b0, "R7 masked");
    hr(A_HCTRL, 32'h1, "R5");
    fr(A_FCTRL, 32'h3, "R5 R8");
    hw(A_MASK, 32'h0);
    step();
    ck_irq(1'b1, "R7");
    fr(A_HCNT, 32'h1, "R7");
    ck_irq(1'b0, "R7 cleared");

    // buffer layout readable from firmware, R2
    for (int k = 0; k < 16; k++) fr(bufa(k), 32'hA500_0000 | 32'(k), "R2");

    // out-of-range and misaligned, R9
    fr(bufa(16), 32'h0, "R9");
    hw(bufa(16), 32'hFFFF_FFFF);
    hr(bufa(16), 32'h0, "R9");
    hr(bufa(15), 32'hA500_000F, "R9");
    hw(8'h89, 32'h5555_5555);
    hr(bufa(0), 32'hA500_0000, "R9");
    hr(8'h0C, 32'h0, "R9");

    // simultaneous lock request, firmware wins, R6
    both_wr(A_HCTRL, 32'h8, A_FCTRL, 32'h8);
    hr(A_HCTRL, 32'h0, "R6");
    fr(A_FCTRL, 32'h8, "R6");
    hw(A_HCTRL, 32'h8);
    hr(A_HCTRL, 32'h0, "R4 refused");
    fw(A_FCTRL, 32'h0);
    fr(A_FCTRL, 32'h0, "R6 release");

    // end-of-read marker, R8
    hw(bufa(0), 32'h0);
    step();
    ck_irq(1'b1, "R8");
    fr(A_FCTRL, 32'h2, "R8");
    ck_irq(1'b0, "R8 cleared");
    fr(A_FCTRL, 32'h0, "R8");
    hw(A_MASK, 32'h0002_0000);
    hw(bufa(0), 32'h0);
    step();
    ck_irq(1'b0, "R8 masked");
    fr(A_FCTRL, 32'h2, "R8");

    // release without request, R5
    hw(A_HCTRL, 32'h8);
    hw(A_HCTRL, 32'h0);
    hr(A_HCTRL, 32'h0, "R5");
    step();
    ck_irq(1'b0, "R5 no request");

    // write collision, R11
    both_wr(bufa(3), 32'h1111_1111, bufa(3), 32'h2222_2222);
    hr(bufa(3), 32'h2222_2222, "R11");

    repeat (3) step();
    checks++;
    if (hq_d.size() != 0 || fq_d.size() != 0) begin
      errors++;
      $display("FAIL R2 reads outstanding actual %0d expected 0", hq_d.size() + fq_d.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule